// File: doc/BRIEF.md
# Service Bridge Control Register Decoder

This block is the register front end of a processor service bridge. It has two slave ports. A narrow sideband configuration port exists only to program the base address register, which places the bridge's 1 MiB memory-mapped window and turns it on or off. A second port carries 64-bit accesses that land inside that window. This port decodes the byte offset and reaches the run-time control registers.

The block stores the registers and computes the window enable and base. It sends the interrupt-control, notification-address and vector-offset fields to a neighbouring interrupt source block, and it sends that block a one-cycle reset pulse on request. Offsets that are not decoded read back as all ones and raise an error flag with the response. The service-processor control and semaphore registers accept writes but discard them.

Both ports follow the same handshake. Every request is taken in the cycle it is presented. Exactly one cycle later a response comes back with registered read data. A write takes effect at the clock edge that samples it.

Top module: `svc_bridge_regs`

## Requirements
- R1: After synchronous reset the window is enabled and its base equals the `DEF_BASE` parameter. Every run-time register reads zero, and `irq_method`, `notif_valid`, `ivt_offset` and `irq_src_rst` are all 0.
- R2: Only 8-byte accesses (`*_len` = 8) are honoured. On either port, a write of any other length changes nothing. An MMIO read of any other length returns all ones with `mmio_rsp_err` set.
- R3: Each request on either port is followed one cycle later by a one-cycle `*_rsp_valid`. An MMIO read of a decoded offset returns the stored 64-bit value. The decoded offsets are 0x58 (interrupt control), 0x60 (ESB cache-inhibited base), 0x68 (notification address), 0x70 (vector offset), 0x20 (service control) and 0x28 (semaphore).
- R4: An MMIO access at any other offset, including a misaligned one, sets `mmio_rsp_err` with its response. A read there returns 0xFFFF_FFFF_FFFF_FFFF, and a write there changes nothing.
- R5: Writes to 0x20 and 0x28 are discarded without error. Reads of those offsets return zero.
- R6: Every sideband read returns all ones. A sideband write has an effect only when `cfg_slot` equals the `BAR_SLOT` parameter; writes to every other slot are ignored.
- R7: Bit 0 of the base address register is the window enable. `win_en` follows that bit, and `win_base` is the register with bit 0 cleared. Both show the new value in the cycle after the write.
- R8: A write to 0x70 stores all 64 bits, and `ivt_offset` then carries bits [63:32] of the written value.
- R9: A write to 0x58 with bit 62 set drives `irq_src_rst` high for exactly the one cycle after the write, and the value is still stored. `irq_method` is bit 63 of the stored interrupt-control value.
- R10: `notif_valid` is bit 0 of the stored notification register, and `notif_addr` is that register with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Sideband request strobe |
| cfg_we | input | 1 | Sideband write (1) or read (0) |
| cfg_slot | input | 8 | Sideband register slot, 256 entries |
| cfg_len | input | 4 | Sideband access length in bytes |
| cfg_wdata | input | 64 | Sideband write data |
| cfg_rsp_valid | output | 1 | Sideband response, one cycle after request |
| cfg_rdata | output | 64 | Sideband read data (always all ones) |
| mmio_req | input | 1 | MMIO request strobe |
| mmio_we | input | 1 | MMIO write (1) or read (0) |
| mmio_addr | input | 20 | Byte offset inside the 1 MiB window |
| mmio_len | input | 4 | MMIO access length in bytes |
| mmio_wdata | input | 64 | MMIO write data |
| mmio_rsp_valid | output | 1 | MMIO response, one cycle after request |
| mmio_rdata | output | 64 | MMIO read data |
| mmio_rsp_err | output | 1 | Access hit no decoded register or had a bad length |
| win_en | output | 1 | MMIO window enabled |
| win_base | output | 64 | MMIO window base address |
| irq_method | output | 1 | Interrupt delivery method select |
| irq_src_rst | output | 1 | One-cycle reset pulse to the interrupt source |
| notif_valid | output | 1 | Notification address valid |
| notif_addr | output | 64 | Notification address |
| ivt_offset | output | 32 | Interrupt source number offset |

## Verification
The properties assume that each port carries at most one request per cycle and that `*_we`, `*_len` and the data are steady while the strobe is high. They also assume that reset is held for at least one clock edge before the first request. The bench drives every input on the falling edge and holds each request for exactly one cycle. It returns the strobe to zero before it samples the response on the next falling edge, so no request overlaps the response of the one before it.

// File: rtl/svc_bridge_pkg.sv
package svc_bridge_pkg;

    localparam int DW         = 64;
    localparam int WIN_BYTES  = 1 << 20;
    localparam int AW         = $clog2(WIN_BYTES);
    localparam int SLOTS      = 256;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int LEN_W      = 4;
    localparam int WORD_BYTES = 8;

    localparam logic [AW-1:0] OFF_SVC_CTL = AW'('h20);
    localparam logic [AW-1:0] OFF_SEMA    = AW'('h28);
    localparam logic [AW-1:0] OFF_IRQ_CTL = AW'('h58);
    localparam logic [AW-1:0] OFF_ESB     = AW'('h60);
    localparam logic [AW-1:0] OFF_NOTIF   = AW'('h68);
    localparam logic [AW-1:0] OFF_IVT     = AW'('h70);

    localparam int METHOD_BIT    = 63;
    localparam int SRC_RST_BIT   = 62;
    localparam int NOTIF_VLD_BIT = 0;
    localparam int WIN_EN_BIT    = 0;
    localparam int IVT_LO        = 32;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_SVC_CTL, SEL_SEMA, SEL_IRQ_CTL, SEL_ESB, SEL_NOTIF, SEL_IVT
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] svc_ctl;
        logic [DW-1:0] sema;
        logic [DW-1:0] irq_ctl;
        logic [DW-1:0] esb;
        logic [DW-1:0] notif;
        logic [DW-1:0] ivt;
    } run_regs_t;

    typedef struct packed {
        logic          irq_ctl;
        logic          esb;
        logic          notif;
        logic          ivt;
        logic [DW-1:0] data;
    } run_wr_t;

    function automatic reg_sel_e decode_off(input logic [AW-1:0] off);
        case (off)
            OFF_SVC_CTL: return SEL_SVC_CTL;
            OFF_SEMA:    return SEL_SEMA;
            OFF_IRQ_CTL: return SEL_IRQ_CTL;
            OFF_ESB:     return SEL_ESB;
            OFF_NOTIF:   return SEL_NOTIF;
            OFF_IVT:     return SEL_IVT;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic logic full_word(input logic [LEN_W-1:0] len);
        return len == LEN_W'(WORD_BYTES);
    endfunction

    function automatic logic [DW-1:0] clear_bit(input logic [DW-1:0] v, input int b);
        logic [DW-1:0] r;
        r    = v;
        r[b] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sbr_sideband.sv
module sbr_sideband
    import svc_bridge_pkg::*;
#(
    parameter logic [SLOT_W-1:0] BAR_SLOT = 8'h12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  logic [LEN_W-1:0]  len,
    input  logic [DW-1:0]     wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rdata,
    output logic              bar_we,
    output logic [DW-1:0]     bar_wdata
);

    assign bar_we    = req && we && (slot == BAR_SLOT) && full_word(len);
    assign bar_wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rdata     <= '0;
        end else begin
            rsp_valid <= req;
            if (req) begin
                rdata <= '1;
            end
        end
    end

endmodule

// File: rtl/sbr_mmio_dec.sv
module sbr_mmio_dec
    import svc_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [LEN_W-1:0] len,
    input  logic [DW-1:0]    wdata,
    input  run_regs_t        regs,
    output run_wr_t          wr,
    output logic             rsp_valid,
    output logic [DW-1:0]    rdata,
    output logic             rsp_err
);

    reg_sel_e      sel;
    logic          ok;
    logic [DW-1:0] rd_mux;

    always_comb begin
        sel        = decode_off(addr);
        ok         = full_word(len);
        wr.data    = wdata;
        wr.irq_ctl = req && we && ok && (sel == SEL_IRQ_CTL);
        wr.esb     = req && we && ok && (sel == SEL_ESB);
        wr.notif   = req && we && ok && (sel == SEL_NOTIF);
        wr.ivt     = req && we && ok && (sel == SEL_IVT);
        case (sel)
            SEL_SVC_CTL: rd_mux = regs.svc_ctl;
            SEL_SEMA:    rd_mux = regs.sema;
            SEL_IRQ_CTL: rd_mux = regs.irq_ctl;
            SEL_ESB:     rd_mux = regs.esb;
            SEL_NOTIF:   rd_mux = regs.notif;
            SEL_IVT:     rd_mux = regs.ivt;
            default:     rd_mux = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rdata     <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req;
            rsp_err   <= req && (!ok || sel == SEL_NONE);
            if (req) begin
                rdata <= we ? '0 : (ok ? rd_mux : '1);
            end
        end
    end

endmodule

// File: rtl/sbr_regfile.sv
module sbr_regfile
    import svc_bridge_pkg::*;
#(
    parameter logic [DW-1:0] DEF_BASE = 64'h0000_0300_0000_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bar_we,
    input  logic [DW-1:0] bar_wdata,
    input  run_wr_t       wr,
    output run_regs_t     regs,
    output logic [DW-1:0] bar_q,
    output logic          src_rst
);

    localparam logic [DW-1:0] EN_MASK = DW'(1) << WIN_EN_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs    <= '0;
            bar_q   <= DEF_BASE | EN_MASK;
            src_rst <= 1'b0;
        end else begin
            src_rst <= wr.irq_ctl && wr.data[SRC_RST_BIT];
            if (bar_we)     bar_q        <= bar_wdata;
            if (wr.irq_ctl) regs.irq_ctl <= wr.data;
            if (wr.esb)     regs.esb     <= wr.data;
            if (wr.notif)   regs.notif   <= wr.data;
            if (wr.ivt)     regs.ivt     <= wr.data;
        end
    end

endmodule

// File: rtl/svc_bridge_regs.sv
module svc_bridge_regs
    import svc_bridge_pkg::*;
#(
    parameter logic [DW-1:0]     DEF_BASE = 64'h0000_0300_0000_0000,
    parameter logic [SLOT_W-1:0] BAR_SLOT = 8'h12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_req,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DW-1:0]     cfg_wdata,
    output logic              cfg_rsp_valid,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              mmio_req,
    input  logic              mmio_we,
    input  logic [AW-1:0]     mmio_addr,
    input  logic [LEN_W-1:0]  mmio_len,
    input  logic [DW-1:0]     mmio_wdata,
    output logic              mmio_rsp_valid,
    output logic [DW-1:0]     mmio_rdata,
    output logic              mmio_rsp_err,
    output logic              win_en,
    output logic [DW-1:0]     win_base,
    output logic              irq_method,
    output logic              irq_src_rst,
    output logic              notif_valid,
    output logic [DW-1:0]     notif_addr,
    output logic [31:0]       ivt_offset
);

    logic          bar_we;
    logic [DW-1:0] bar_wdata;
    logic [DW-1:0] bar_q;
    run_regs_t     regs;
    run_wr_t       wr;

    sbr_sideband #(.BAR_SLOT(BAR_SLOT)) u_side (
        .clk(clk), .rst(rst), .req(cfg_req), .we(cfg_we), .slot(cfg_slot),
        .len(cfg_len), .wdata(cfg_wdata), .rsp_valid(cfg_rsp_valid),
        .rdata(cfg_rdata), .bar_we(bar_we), .bar_wdata(bar_wdata)
    );

    sbr_mmio_dec u_dec (
        .clk(clk), .rst(rst), .req(mmio_req), .we(mmio_we), .addr(mmio_addr),
        .len(mmio_len), .wdata(mmio_wdata), .regs(regs), .wr(wr),
        .rsp_valid(mmio_rsp_valid), .rdata(mmio_rdata), .rsp_err(mmio_rsp_err)
    );

    sbr_regfile #(.DEF_BASE(DEF_BASE)) u_regs (
        .clk(clk), .rst(rst), .bar_we(bar_we), .bar_wdata(bar_wdata),
        .wr(wr), .regs(regs), .bar_q(bar_q), .src_rst(irq_src_rst)
    );

    assign win_en      = bar_q[WIN_EN_BIT];
    assign win_base    = clear_bit(bar_q, WIN_EN_BIT);
    assign irq_method  = regs.irq_ctl[METHOD_BIT];
    assign notif_valid = regs.notif[NOTIF_VLD_BIT];
    assign notif_addr  = clear_bit(regs.notif, NOTIF_VLD_BIT);
    assign ivt_offset  = regs.ivt[DW-1:IVT_LO];

endmodule

// File: rtl/svc_bridge_regs_chk.sv
module svc_bridge_regs_chk
    import svc_bridge_pkg::*;
#(
    parameter logic [SLOT_W-1:0] BAR_SLOT = 8'h12
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_req,
    input logic              cfg_we,
    input logic [SLOT_W-1:0] cfg_slot,
    input logic [LEN_W-1:0]  cfg_len,
    input logic              cfg_en_bit,
    input logic              cfg_rsp_valid,
    input logic [DW-1:0]     cfg_rdata,
    input logic              mmio_req,
    input logic              mmio_we,
    input logic [AW-1:0]     mmio_addr,
    input logic [LEN_W-1:0]  mmio_len,
    input logic [31:0]       mmio_wd_hi,
    input logic              mmio_wd_rst,
    input logic              mmio_rsp_valid,
    input logic [DW-1:0]     mmio_rdata,
    input logic              mmio_rsp_err,
    input logic              win_en,
    input logic              irq_src_rst,
    input logic [31:0]       ivt_offset
);

    // R3: one response per request, one cycle later
    a_r3_mmio_rsp: assert property (@(posedge clk) disable iff (rst)
        mmio_req |=> mmio_rsp_valid);
    a_r3_mmio_idle: assert property (@(posedge clk) disable iff (rst)
        !mmio_req |=> !mmio_rsp_valid);
    a_r3_cfg_rsp: assert property (@(posedge clk) disable iff (rst)
        cfg_req |=> cfg_rsp_valid);

    // R6: sideband reads give all ones
    a_r6_cfg_read_ones: assert property (@(posedge clk) disable iff (rst)
        cfg_req && !cfg_we |=> cfg_rdata == '1);

    // R2: short MMIO reads give all ones and an error
    a_r2_short_read: assert property (@(posedge clk) disable iff (rst)
        mmio_req && !mmio_we && mmio_len != LEN_W'(WORD_BYTES)
        |=> mmio_rdata == '1 && mmio_rsp_err);

    // R7: enable follows the written bit
    a_r7_win_en: assert property (@(posedge clk) disable iff (rst)
        cfg_req && cfg_we && cfg_slot == BAR_SLOT && cfg_len == LEN_W'(WORD_BYTES)
        |=> win_en == $past(cfg_en_bit));

    // R8: vector offset export
    a_r8_ivt_export: assert property (@(posedge clk) disable iff (rst)
        mmio_req && mmio_we && mmio_addr == OFF_IVT && mmio_len == LEN_W'(WORD_BYTES)
        |=> ivt_offset == $past(mmio_wd_hi));

    // R9: pulse only after an interrupt-control write with the reset bit
    a_r9_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        irq_src_rst |-> $past(mmio_req && mmio_we && mmio_addr == OFF_IRQ_CTL
                              && mmio_len == LEN_W'(WORD_BYTES) && mmio_wd_rst));
    a_r9_pulse_issue: assert property (@(posedge clk) disable iff (rst)
        mmio_req && mmio_we && mmio_addr == OFF_IRQ_CTL
        && mmio_len == LEN_W'(WORD_BYTES) && mmio_wd_rst |=> irq_src_rst);

endmodule

bind svc_bridge_regs svc_bridge_regs_chk #(.BAR_SLOT(BAR_SLOT)) u_chk (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_slot(cfg_slot), .cfg_len(cfg_len), .cfg_en_bit(cfg_wdata[0]),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rdata(cfg_rdata),
    .mmio_req(mmio_req), .mmio_we(mmio_we), .mmio_addr(mmio_addr),
    .mmio_len(mmio_len), .mmio_wd_hi(mmio_wdata[63:32]),
    .mmio_wd_rst(mmio_wdata[62]), .mmio_rsp_valid(mmio_rsp_valid),
    .mmio_rdata(mmio_rdata), .mmio_rsp_err(mmio_rsp_err), .win_en(win_en),
    .irq_src_rst(irq_src_rst), .ivt_offset(ivt_offset)
);

// File: tb/svc_bridge_regs_test.sv
module svc_bridge_regs_test;

    localparam logic [63:0] DEF_BASE = 64'h0000_0300_0000_0000;
    localparam logic [7:0]  BAR_SLOT = 8'h12;
    localparam logic [63:0] ONES     = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_req = 1'b0, cfg_we = 1'b0;
    logic [7:0]  cfg_slot = '0;
    logic [3:0]  cfg_len = '0;
    logic [63:0] cfg_wdata = '0;
    logic        cfg_rsp_valid;
    logic [63:0] cfg_rdata;
    logic        mmio_req = 1'b0, mmio_we = 1'b0;
    logic [19:0] mmio_addr = '0;
    logic [3:0]  mmio_len = '0;
    logic [63:0] mmio_wdata = '0;
    logic        mmio_rsp_valid;
    logic [63:0] mmio_rdata;
    logic        mmio_rsp_err;
    logic        win_en;
    logic [63:0] win_base;
    logic        irq_method, irq_src_rst, notif_valid;
    logic [63:0] notif_addr;
    logic [31:0] ivt_offset;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    svc_bridge_regs #(.DEF_BASE(DEF_BASE), .BAR_SLOT(BAR_SLOT)) uut (
        .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_slot(cfg_slot), .cfg_len(cfg_len), .cfg_wdata(cfg_wdata),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rdata(cfg_rdata),
        .mmio_req(mmio_req), .mmio_we(mmio_we), .mmio_addr(mmio_addr),
        .mmio_len(mmio_len), .mmio_wdata(mmio_wdata),
        .mmio_rsp_valid(mmio_rsp_valid), .mmio_rdata(mmio_rdata),
        .mmio_rsp_err(mmio_rsp_err), .win_en(win_en), .win_base(win_base),
        .irq_method(irq_method), .irq_src_rst(irq_src_rst),
        .notif_valid(notif_valid), .notif_addr(notif_addr),
        .ivt_offset(ivt_offset)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        we;
        logic [3:0]  len;
        logic [19:0] addr;
        logic [63:0] wdata;
        logic [63:0] erd;
        logic        eerr;
        logic        chk;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{4'd5, 1'b0, 4'd8, 20'h00020, 64'h0, 64'h0, 1'b0, 1'b1},
        '{4'd3, 1'b1, 4'd8, 20'h00058, 64'h8000_0000_0000_0001, 64'h0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 4'd8, 20'h00058, 64'h0, 64'h8000_0000_0000_0001, 1'b0, 1'b1},
        '{4'd3, 1'b1, 4'd8, 20'h00060, 64'h0000_1234_5678_9000, 64'h0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 4'd8, 20'h00060, 64'h0, 64'h0000_1234_5678_9000, 1'b0, 1'b1},
        '{4'd3, 1'b1, 4'd8, 20'h00068, 64'h0000_00AB_CDEF_0001, 64'h0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 4'd8, 20'h00068, 64'h0, 64'h0000_00AB_CDEF_0001, 1'b0, 1'b1},
        '{4'd3, 1'b1, 4'd8, 20'h00070, 64'h0000_0040_DEAD_BEEF, 64'h0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 4'd8, 20'h00070, 64'h0, 64'h0000_0040_DEAD_BEEF, 1'b0, 1'b1},
        '{4'd5, 1'b1, 4'd8, 20'h00020, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0},
        '{4'd5, 1'b0, 4'd8, 20'h00020, 64'h0, 64'h0, 1'b0, 1'b1},
        '{4'd5, 1'b1, 4'd8, 20'h00028, 64'h5555_5555_5555_5555, 64'h0, 1'b0, 1'b0},
        '{4'd5, 1'b0, 4'd8, 20'h00028, 64'h0, 64'h0, 1'b0, 1'b1},
        '{4'd4, 1'b0, 4'd8, 20'h00030, 64'h0, ONES, 1'b1, 1'b1},
        '{4'd4, 1'b0, 4'd8, 20'h0005C, 64'h0, ONES, 1'b1, 1'b1},
        '{4'd4, 1'b1, 4'd8, 20'h00078, 64'h1111_2222_3333_4444, 64'h0, 1'b1, 1'b0},
        '{4'd2, 1'b0, 4'd4, 20'h00060, 64'h0, ONES, 1'b1, 1'b1},
        '{4'd2, 1'b1, 4'd4, 20'h00060, 64'h0BAD_0BAD_0BAD_0BAD, 64'h0, 1'b1, 1'b0},
        '{4'd2, 1'b0, 4'd8, 20'h00060, 64'h0, 64'h0000_1234_5678_9000, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic mmio_xfer(input logic we, input logic [19:0] a, input logic [3:0] l,
                             input logic [63:0] d, output logic rv,
                             output logic [63:0] rd, output logic er);
        @(negedge clk);
        mmio_req = 1'b1; mmio_we = we; mmio_addr = a; mmio_len = l; mmio_wdata = d;
        @(negedge clk);
        mmio_req = 1'b0;
        rv = mmio_rsp_valid; rd = mmio_rdata; er = mmio_rsp_err;
    endtask

    task automatic cfg_xfer(input logic we, input logic [7:0] s, input logic [3:0] l,
                            input logic [63:0] d, output logic rv, output logic [63:0] rd);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = we; cfg_slot = s; cfg_len = l; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0;
        rv = cfg_rsp_valid; rd = cfg_rdata;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic rv, er;
        logic [63:0] rd;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 win_en", 64'(win_en), 64'd1);
        chk("R1 win_base", win_base, DEF_BASE);
        chk("R1 irq_method", 64'(irq_method), 64'd0);
        chk("R1 notif_valid", 64'(notif_valid), 64'd0);
        chk("R1 ivt_offset", 64'(ivt_offset), 64'd0);
        chk("R1 irq_src_rst", 64'(irq_src_rst), 64'd0);
        mmio_xfer(1'b0, 20'h58, 4'd8, 64'h0, rv, rd, er);
        chk("R1 irq ctl reads zero", rd, 64'h0);

        // R2 R3 R4 R5 table walk
        for (int i = 0; i < NV; i++) begin
            mmio_xfer(VEC[i].we, VEC[i].addr, VEC[i].len, VEC[i].wdata, rv, rd, er);
            chk($sformatf("R3 rsp_valid vec %0d", i), 64'(rv), 64'd1);
            chk($sformatf("R%0d err vec %0d", VEC[i].rq, i), 64'(er), 64'(VEC[i].eerr));
            if (VEC[i].chk)
                chk($sformatf("R%0d rdata vec %0d", VEC[i].rq, i), rd, VEC[i].erd);
        end
        @(negedge clk);
        chk("R3 rsp drops", 64'(mmio_rsp_valid), 64'd0);

        // R8 R9 R10 exports after the table
        chk("R9 irq_method", 64'(irq_method), 64'd1);
        chk("R8 ivt_offset", 64'(ivt_offset), 64'h40);
        chk("R10 notif_valid", 64'(notif_valid), 64'd1);
        chk("R10 notif_addr", notif_addr, 64'h0000_00AB_CDEF_0000);
        chk("R9 no pulse without bit", 64'(irq_src_rst), 64'd0);

        // R9 pulse
        mmio_xfer(1'b1, 20'h58, 4'd8, 64'h4000_0000_0000_0000, rv, rd, er);
        chk("R9 pulse high", 64'(irq_src_rst), 64'd1);
        chk("R9 method now 0", 64'(irq_method), 64'd0);
        @(negedge clk);
        chk("R9 pulse one cycle", 64'(irq_src_rst), 64'd0);
        mmio_xfer(1'b0, 20'h58, 4'd8, 64'h0, rv, rd, er);
        chk("R9 value stored", rd, 64'h4000_0000_0000_0000);

        // R6 sideband
        cfg_xfer(1'b0, BAR_SLOT, 4'd8, 64'h0, rv, rd);
        chk("R6 cfg rsp_valid", 64'(rv), 64'd1);
        chk("R6 cfg read ones", rd, ONES);
        cfg_xfer(1'b1, 8'h05, 4'd8, 64'h0000_0000_7770_0000, rv, rd);
        chk("R6 other slot ignored", win_base, DEF_BASE);
        chk("R6 other slot en", 64'(win_en), 64'd1);
        // R2 narrow sideband write
        cfg_xfer(1'b1, BAR_SLOT, 4'd4, 64'h0000_0000_7770_0000, rv, rd);
        chk("R2 cfg short write ignored", win_base, DEF_BASE);

        // R7 base register
        cfg_xfer(1'b1, BAR_SLOT, 4'd8, 64'h0000_0000_8000_0000, rv, rd);
        chk("R7 disabled", 64'(win_en), 64'd0);
        chk("R7 base when off", win_base, 64'h0000_0000_8000_0000);
        cfg_xfer(1'b1, BAR_SLOT, 4'd8, 64'h0000_0000_9010_0001, rv, rd);
        chk("R7 enabled", 64'(win_en), 64'd1);
        chk("R7 base clears flag", win_base, 64'h0000_0000_9010_0000);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 base after reset", win_base, DEF_BASE);
        chk("R1 en after reset", 64'(win_en), 64'd1);
        chk("R1 ivt after reset", 64'(ivt_offset), 64'd0);
        mmio_xfer(1'b0, 20'h68, 4'd8, 64'h0, rv, rd, er);
        chk("R1 notif reads zero", rd, 64'h0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule